// File: doc/BRIEF.md
# Page-Aware Burst Splitter

This block sits between a 32-bit bus and an external memory controller. It takes one burst request at a time and turns it into one or more burst commands that the memory can execute. A request has a byte address, a length of 1, 2, 4 or 8 words, and a type flag that says whether the burst increments or wraps. The block converts it using two configuration inputs: the page length of the attached device, and a flag that says whether the device can run wrapping bursts itself.

An incrementing burst that is longer than the device page is cut into consecutive page-sized commands. A wrapping burst is issued as one native wrapping command when the device can wrap and the burst fits in a page. Otherwise the block emulates it with plain incrementing commands. The first command runs from the start address up to the end of the wrap block. A second command runs from the aligned block base up to the start address. Each of these pieces is also cut at page boundaries.

Both sides use a valid/ready handshake. The controller is a three-state machine:
- From BSP_IDLE, it goes to BSP_ISSUE when it accepts a legal request, and to BSP_FAULT when it accepts a misaligned request.
- BSP_ISSUE stays in BSP_ISSUE while beats remain after a command is accepted. It returns to BSP_IDLE when the last command is accepted.
- BSP_FAULT lasts exactly one cycle and then returns to BSP_IDLE.

Top module: `page_burst_splitter`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0 and err_misalign is 0.
- R2: The length code req_len selects the burst length: 00 = 1 word, 01 = 2, 10 = 4, 11 = 8. A one-word request produces exactly one command. That command has 1 beat, the unmodified byte address, cmd_wrap = 0, and cmd_width equal to req_width (00 byte, 01 halfword, 10 word).
- R3: The page field cfg_page_sel gives the page length in words: 00 = 4, 01 = 8, 10 = 16, and 11 (reserved) = 4. An incrementing burst longer than the page is issued as consecutive commands of one page each, at ascending addresses.
- R4: A command with cmd_wrap = 0 never crosses a page boundary. Its word offset within the page plus its beat count never exceeds the page length.
- R5: A multi-beat request is misaligned in two cases:
  - an incrementing request whose address is not a multiple of 4 × length bytes;
  - a wrapping request whose address has nonzero bits [1:0].
  A misaligned request produces no command. err_misalign is 1 for exactly one cycle, the cycle after acceptance.
- R6: A wrapping request gets native handling when cfg_wrap_ok = 1 and its length is no greater than the page. It is then issued as one command with cmd_wrap = 1, the start address, and the full length.
- R7: Any other wrapping request is emulated with cmd_wrap = 0 commands. The commands run first from the start address to the end of the aligned wrap block, then from the block base up to the start address. Each command is cut at page boundaries, and the beats add up to the request length.
- R8: While cmd_valid is 1 and cmd_ready is 0, cmd_addr, cmd_beats, cmd_wrap and cmd_width hold steady. req_ready is 1 only when no command is pending. The block returns to req_ready = 1 in the cycle after the last command is accepted.
- R9: Every command with more than one beat carries cmd_width = 10 (word).
- R10: The page length and the wrap-support flag are sampled when a request is accepted. Changing them while that request is being issued has no effect on its commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_page_sel | input | 2 | Device page length code |
| cfg_wrap_ok | input | 1 | Device executes wrapping bursts natively |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Request byte address |
| req_len | input | 2 | Burst length code |
| req_wrap | input | 1 | 1 = wrapping burst, 0 = incrementing |
| req_width | input | 2 | Access width for one-word requests |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Memory side takes the command |
| cmd_addr | output | ADDR_W | Command start byte address |
| cmd_beats | output | 5 | Command beat count |
| cmd_wrap | output | 1 | Command is a native wrapping burst |
| cmd_width | output | 2 | Command access width |
| err_misalign | output | 1 | One-cycle pulse for a dropped misaligned request |

## Verification
The assertions check on every cycle the rules that apply to any single command or cycle:
- a non-wrapping command stays inside its page;
- a command's beat count is nonzero and never larger than the beats still owed;
- a stalled command holds its fields;
- multi-beat commands use word width;
- request readiness and a pending command never coexist;
- the error pulse lasts one cycle.

The bench's scenarios are needed for anything that depends on a whole sequence of commands:
- how a burst is cut up and in what order the pieces come out;
- the native versus emulated wrapping decision;
- the reserved page code;
- sampling the configuration at acceptance.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    // Width of beat counts, page lengths and burst lengths (max 16)
    localparam int unsigned CNT_W = 5;

    typedef enum logic [1:0] {
        BSP_IDLE  = 2'd0,
        BSP_ISSUE = 2'd1,
        BSP_FAULT = 2'd2
    } bsp_state_e;

    // Word count from a request length code
    function automatic logic [CNT_W-1:0] len_from_code(input logic [1:0] code);
        return 5'd1 << code;
    endfunction

    // Page length in words from the page select field; 11 falls back to 4
    function automatic logic [CNT_W-1:0] page_from_code(input logic [1:0] code);
        return (code == 2'b11) ? 5'd4 : (5'd4 << code);
    endfunction

endpackage

// File: rtl/bsplit_decode.sv
module bsplit_decode
    import bsplit_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          len_code,
    input  logic                is_wrap,
    input  logic [1:0]          page_sel,
    input  logic                wrap_ok,
    output logic [CNT_W-1:0]    len_words,
    output logic [CNT_W-1:0]    page_words,
    output logic                misaligned,
    output logic                native_wrap,
    output logic [ADDR_W-3:0]   base_word
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [ADDR_W-1:0] span_bytes;
    logic [ADDR_W-1:0] span_mask;
    logic              multi;

    always_comb begin
        len_words  = len_from_code(len_code);
        page_words = page_from_code(page_sel);
        multi      = (len_words != 5'd1);

        // Byte span of the whole burst, used for the incrementing alignment rule
        span_bytes = {{(ADDR_W-CNT_W-2){1'b0}}, len_words, 2'b00};
        span_mask  = span_bytes - {{(ADDR_W-1){1'b0}}, 1'b1};

        if (!multi)
            misaligned = 1'b0;
        else if (is_wrap)
            misaligned = (addr[1:0] != 2'b00);
        else
            misaligned = ((addr & span_mask) != '0);

        native_wrap = is_wrap && multi && wrap_ok && (len_words <= page_words);

        base_word = addr[ADDR_W-1:2]
                  & ~{{(WORD_W-CNT_W){1'b0}}, (len_words - 5'd1)};
    end

endmodule

// File: rtl/bsplit_piece.sv
module bsplit_piece
    import bsplit_pkg::*;
(
    input  logic [CNT_W-1:0] cur_lo,
    input  logic [CNT_W-1:0] remain,
    input  logic [CNT_W-1:0] len_words,
    input  logic [CNT_W-1:0] page_words,
    input  logic             native,
    output logic [CNT_W-1:0] beats
);
    logic [CNT_W-1:0] to_page;
    logic [CNT_W-1:0] to_block;
    logic [CNT_W-1:0] nearer;

    always_comb begin
        // Distance to the next page boundary and to the end of the wrap block
        to_page  = page_words - (cur_lo & (page_words - 5'd1));
        to_block = len_words  - (cur_lo & (len_words  - 5'd1));
        nearer   = (to_page < to_block) ? to_page : to_block;

        if (native)
            beats = remain;
        else
            beats = (remain < nearer) ? remain : nearer;
    end

endmodule

// File: rtl/page_burst_splitter.sv
module page_burst_splitter
    import bsplit_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_page_sel,
    input  logic              cfg_wrap_ok,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_len,
    input  logic              req_wrap,
    input  logic [1:0]        req_width,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [4:0]        cmd_beats,
    output logic              cmd_wrap,
    output logic [1:0]        cmd_width,
    output logic              err_misalign
);
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam logic [1:0]  WIDTH_WORD = 2'b10;

    bsp_state_e state_q, state_d;

    logic [WORD_W-1:0] cur_q,  base_q;
    logic [CNT_W-1:0]  len_q,  rem_q, page_q;
    logic              native_q;
    logic [1:0]        width_q, lo_q;

    // Decoded request
    logic [CNT_W-1:0]  dec_len, dec_page;
    logic              dec_misaligned, dec_native;
    logic [WORD_W-1:0] dec_base;

    // Current piece
    logic [CNT_W-1:0]  piece_beats;
    logic [WORD_W-1:0] next_word;
    logic [WORD_W-1:0] block_end;
    logic [CNT_W-1:0]  rem_after;

    logic req_take, cmd_take;

    bsplit_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr        (req_addr),
        .len_code    (req_len),
        .is_wrap     (req_wrap),
        .page_sel    (cfg_page_sel),
        .wrap_ok     (cfg_wrap_ok),
        .len_words   (dec_len),
        .page_words  (dec_page),
        .misaligned  (dec_misaligned),
        .native_wrap (dec_native),
        .base_word   (dec_base)
    );

    bsplit_piece u_piece (
        .cur_lo     (cur_q[CNT_W-1:0]),
        .remain     (rem_q),
        .len_words  (len_q),
        .page_words (page_q),
        .native     (native_q),
        .beats      (piece_beats)
    );

    assign req_take  = req_valid && req_ready;
    assign cmd_take  = cmd_valid && cmd_ready;
    assign block_end = base_q + {{(WORD_W-CNT_W){1'b0}}, len_q};
    assign rem_after = rem_q - piece_beats;

    always_comb begin
        next_word = cur_q + {{(WORD_W-CNT_W){1'b0}}, piece_beats};
        if (next_word == block_end)
            next_word = base_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BSP_IDLE: begin
                if (req_take)
                    state_d = dec_misaligned ? BSP_FAULT : BSP_ISSUE;
            end
            BSP_ISSUE: begin
                if (cmd_take && (rem_after == '0))
                    state_d = BSP_IDLE;
            end
            BSP_FAULT: state_d = BSP_IDLE;
            default:   state_d = BSP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= BSP_IDLE;
        else
            state_q <= state_d;
    end

    // Burst cursor: loaded at acceptance, advanced per accepted command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            base_q   <= '0;
            len_q    <= 5'd1;
            rem_q    <= '0;
            page_q   <= 5'd4;
            native_q <= 1'b0;
            width_q  <= 2'b00;
            lo_q     <= 2'b00;
        end else if (state_q == BSP_IDLE && req_take) begin
            cur_q    <= req_addr[ADDR_W-1:2];
            base_q   <= dec_base;
            len_q    <= dec_len;
            rem_q    <= dec_len;
            page_q   <= dec_page;
            native_q <= dec_native;
            width_q  <= (dec_len == 5'd1) ? req_width : WIDTH_WORD;
            lo_q     <= req_addr[1:0];
        end else if (state_q == BSP_ISSUE && cmd_take) begin
            cur_q <= next_word;
            rem_q <= rem_after;
            lo_q  <= 2'b00;
        end
    end

    // Outputs
    always_comb begin
        req_ready    = (state_q == BSP_IDLE);
        cmd_valid    = (state_q == BSP_ISSUE);
        err_misalign = (state_q == BSP_FAULT);
        cmd_addr     = {cur_q, lo_q};
        cmd_beats    = piece_beats;
        cmd_wrap     = native_q;
        cmd_width    = width_q;
    end

    // R4
    no_page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_wrap) |->
            ({1'b0, (cmd_addr[CNT_W+1:2] & (page_q - 5'd1))} + {1'b0, cmd_beats}) <= {1'b0, page_q});

    // R7
    beats_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_beats != '0) && (cmd_beats <= rem_q));

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_addr) && $stable(cmd_beats)
             && $stable(cmd_wrap) && $stable(cmd_width)));

    // R8
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && cmd_valid));

    // R5
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_misalign |=> (!err_misalign && req_ready && !cmd_valid));

    // R9
    multi_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_beats > 5'd1) |-> (cmd_width == WIDTH_WORD));

endmodule

// File: tb/sim_page_burst_splitter.sv
module sim_page_burst_splitter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_page_sel = 2'b00;
    logic        cfg_wrap_ok = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic        req_wrap = 1'b0;
    logic [1:0]  req_width = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_addr;
    logic [4:0]  cmd_beats;
    logic        cmd_wrap;
    logic [1:0]  cmd_width;
    logic        err_misalign;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] exp_addr[16];
    int          exp_beats[16];
    logic        exp_wrap[16];
    logic [1:0]  exp_width[16];
    int          exp_n;
    logic        exp_err;

    logic [31:0] got_addr[16];
    int          got_beats[16];
    logic        got_wrap[16];
    logic [1:0]  got_width[16];
    int          got_n;
    int          err_seen;
    logic        err_first;
    logic        idle_after;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_burst_splitter u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_page_sel(cfg_page_sel), .cfg_wrap_ok(cfg_wrap_ok),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_wrap(req_wrap),
        .req_width(req_width),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_beats(cmd_beats), .cmd_wrap(cmd_wrap),
        .cmd_width(cmd_width), .err_misalign(err_misalign)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference: walk the beats in issue order, start a new command on any
    // address jump or page start.
    task automatic model(input logic [31:0] a, input logic [1:0] lc,
                         input logic wr, input logic [1:0] wd,
                         input logic [1:0] sel, input logic wok);
        int len, pg, w, base, off, cur, prev;
        len = 1 << lc;
        pg  = (sel == 2'b11) ? 4 : (4 << sel);
        w   = int'(a >> 2);
        exp_n = 0;
        exp_err = (len > 1) && (wr ? (a[1:0] != 2'b00) : ((a % (4*len)) != 0));
        if (exp_err) return;
        if (wr && len > 1 && wok && len <= pg) begin
            exp_addr[0] = a; exp_beats[0] = len; exp_wrap[0] = 1'b1;
            exp_width[0] = 2'b10; exp_n = 1;
            return;
        end
        base = w - (w % len);
        off  = w - base;
        prev = -2;
        for (int i = 0; i < len; i++) begin
            cur = base + ((off + i) % len);
            if (i == 0 || cur != prev + 1 || (cur % pg) == 0) begin
                exp_addr[exp_n]  = (len == 1) ? a : 32'(cur * 4);
                exp_beats[exp_n] = 1;
                exp_wrap[exp_n]  = 1'b0;
                exp_width[exp_n] = (len == 1) ? wd : 2'b10;
                exp_n++;
            end else begin
                exp_beats[exp_n-1]++;
            end
            prev = cur;
        end
    endtask

    task automatic run_req(input logic [31:0] a, input logic [1:0] lc,
                           input logic wr, input logic [1:0] wd,
                           input logic stall, input logic chg,
                           input logic [1:0] new_sel, input logic new_wok);
        logic        hold;
        logic [31:0] h_addr;
        logic [4:0]  h_beats;
        logic        h_wrap;
        logic [1:0]  h_width;
        hold = 1'b0; h_addr = '0; h_beats = '0; h_wrap = 1'b0; h_width = '0;
        got_n = 0; err_seen = 0; err_first = 1'b0; idle_after = 1'b0;
        @(negedge clk);
        req_addr = a; req_len = lc; req_wrap = wr; req_width = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (chg) begin
            cfg_page_sel = new_sel;
            cfg_wrap_ok  = new_wok;
        end
        for (int cyc = 0; cyc < 64; cyc++) begin
            if (cyc > 0) @(negedge clk);
            cmd_ready = stall ? cyc[0] : 1'b1;
            if (err_misalign) begin
                err_seen++;
                if (cyc == 0) err_first = 1'b1;
            end
            if (hold) begin
                check("R8", "held addr",  cmd_addr, h_addr);
                check("R8", "held beats", 32'(cmd_beats), 32'(h_beats));
                check("R8", "held wrap",  32'(cmd_wrap), 32'(h_wrap));
                check("R8", "held width", 32'(cmd_width), 32'(h_width));
            end
            if (cmd_valid && cmd_ready && got_n < 16) begin
                got_addr[got_n]  = cmd_addr;
                got_beats[got_n] = int'(cmd_beats);
                got_wrap[got_n]  = cmd_wrap;
                got_width[got_n] = cmd_width;
                got_n++;
            end
            hold = cmd_valid && !cmd_ready;
            h_addr = cmd_addr; h_beats = cmd_beats;
            h_wrap = cmd_wrap; h_width = cmd_width;
            if (req_ready && !cmd_valid && !err_misalign) begin
                idle_after = 1'b1;
                break;
            end
        end
        cmd_ready = 1'b1;
    endtask

    task automatic compare(input string tag);
        check(tag, "command count", 32'(got_n), 32'(exp_n));
        check("R5", "error pulses", 32'(err_seen), exp_err ? 32'd1 : 32'd0);
        if (exp_err) check("R5", "error timing", 32'(err_first), 32'd1);
        check("R8", "returns idle", 32'(idle_after), 32'd1);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(tag, "addr",  got_addr[i], exp_addr[i]);
            check(tag, "beats", 32'(got_beats[i]), 32'(exp_beats[i]));
            check(tag, "wrap",  32'(got_wrap[i]), 32'(exp_wrap[i]));
            check(tag, "width", 32'(got_width[i]), 32'(exp_width[i]));
        end
    endtask

    task automatic scenario(input string tag, input logic [1:0] sel,
                            input logic wok, input logic [31:0] a,
                            input logic [1:0] lc, input logic wr,
                            input logic [1:0] wd, input logic stall);
        cfg_page_sel = sel; cfg_wrap_ok = wok;
        model(a, lc, wr, wd, sel, wok);
        run_req(a, lc, wr, wd, stall, 1'b0, sel, wok);
        compare(tag);
    endtask

    task automatic test_reset();
        check("R1", "req_ready", 32'(req_ready), 32'd1);
        check("R1", "cmd_valid", 32'(cmd_valid), 32'd0);
        check("R1", "err_misalign", 32'(err_misalign), 32'd0);
    endtask

    // R10: config changes after acceptance must not alter the split
    task automatic test_cfg_sampled();
        cfg_page_sel = 2'b00; cfg_wrap_ok = 1'b0;
        model(32'h0000_0080, 2'b11, 1'b0, 2'b10, 2'b00, 1'b0);
        run_req(32'h0000_0080, 2'b11, 1'b0, 2'b10, 1'b0, 1'b1, 2'b10, 1'b1);
        compare("R10");
        cfg_page_sel = 2'b00; cfg_wrap_ok = 1'b0;
        model(32'h0000_0058, 2'b10, 1'b1, 2'b10, 2'b00, 1'b0);
        run_req(32'h0000_0058, 2'b10, 1'b1, 2'b10, 1'b0, 1'b1, 2'b01, 1'b1);
        compare("R10");
    endtask

    task automatic finish_report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        // R2 single byte access at odd address
        scenario("R2", 2'b00, 1'b0, 32'h0000_0103, 2'b00, 1'b0, 2'b00, 1'b0);
        // R2 single halfword access, wrap flag ignored
        scenario("R2", 2'b01, 1'b1, 32'h0000_0202, 2'b00, 1'b1, 2'b01, 1'b0);
        // R3 eight words fit a 16-word page
        scenario("R3", 2'b10, 1'b0, 32'h0000_0040, 2'b11, 1'b0, 2'b10, 1'b0);
        // R3 eight words on a 4-word page
        scenario("R3", 2'b00, 1'b0, 32'h0000_0020, 2'b11, 1'b0, 2'b10, 1'b0);
        // R3 reserved page code acts as 4 words
        scenario("R3", 2'b11, 1'b0, 32'h0000_0060, 2'b11, 1'b0, 2'b10, 1'b0);
        // R9 four words on an 8-word page
        scenario("R9", 2'b01, 1'b0, 32'h0000_0010, 2'b10, 1'b0, 2'b10, 1'b0);
        // R5 misaligned incrementing request
        scenario("R5", 2'b01, 1'b0, 32'h0000_0018, 2'b10, 1'b0, 2'b10, 1'b0);
        // R5 wrapping request with byte offset
        scenario("R5", 2'b01, 1'b1, 32'h0000_0042, 2'b01, 1'b1, 2'b10, 1'b0);
        // R6 native wrap
        scenario("R6", 2'b01, 1'b1, 32'h0000_0038, 2'b10, 1'b1, 2'b10, 1'b0);
        // R7 emulated wrap, device without wrap support
        scenario("R7", 2'b01, 1'b0, 32'h0000_0038, 2'b10, 1'b1, 2'b10, 1'b0);
        // R7 wrap longer than page forces emulation with page chopping
        scenario("R7", 2'b00, 1'b1, 32'h0000_0044, 2'b11, 1'b1, 2'b10, 1'b0);
        // R7 emulated wrap starting at the block base
        scenario("R7", 2'b00, 1'b0, 32'h0000_0030, 2'b10, 1'b1, 2'b10, 1'b0);
        // R8 chopped burst with a stalling memory side
        scenario("R8", 2'b00, 1'b0, 32'h0000_00A0, 2'b11, 1'b0, 2'b10, 1'b1);
        // R4 emulated wrap with stalls, every piece inside its page
        scenario("R4", 2'b00, 1'b0, 32'h0000_007C, 2'b11, 1'b1, 2'b10, 1'b1);
        test_cfg_sampled();
        finish_report();
    end

endmodule